// File: doc/BRIEF.md
# Power-Up Strap Capture and Test-Mode Controller

This block records the board configuration straps once, at the moment the active-low power-good input first goes low after a power-on reset. From the three captured frequency-select straps it produces a compact CPU frequency code. From the captured pair-select strap it decides whether the shared differential output pair carries a CPU debug clock or an SRC clock. The captured select straps can also be read back by software.

The block also controls the output mode of the clock outputs. The mode is normal, all outputs high impedance, or a reference clock divided by an even factor. Test mode can be entered in two ways: a test-select strap captured high, or a software entry bit set after the straps have been captured. A strap entry lets the live test-mode pin pick the mode. A software entry hands that choice to a software mode bit. Once entered, test mode lasts until the next power-on reset.

Top module: `strap_test_ctrl`

## Requirements
- R1: While `rstN` is low and just after it is released, every output is zero: `strapReadback`, `freqReserved`, `cpuPairSel`, `refDivClk`, `freqCode` (0 is the 100 MHz code) and `outMode` (0 is normal).
- R2: The straps are captured on the first rising clock edge after reset at which `pwrGoodN` is low. Later changes on the strap pins or on `pwrGoodN` leave the captured values unchanged. `strapReadback` shows the captured select straps with C in bit 2, B in bit 1 and A in bit 0.
- R3: `freqCode` encodes the CPU frequency as 0=100, 1=133.33, 2=166.66, 3=200, 4=266.66, 5=333.33 and 6=400 MHz. The strap values {C,B,A} map as 000→4, 001→1, 010→3, 011→2, 100→5, 101→0 and 110→6.
- R4: `cpuPairSel` equals the captured pair-select strap (1 = CPU debug pair, 0 = SRC pair).
- R5: With the test-select strap captured high and no software entry, `outMode` follows the live `testModePin`: 0 gives 1 (high impedance) and 1 gives 2 (divided reference).
- R6: `swTestEntry` high at a clock edge after capture enters test mode. From then on only `swTestRefN` picks the mode (0 gives 1, 1 gives 2) and `testModePin` has no effect. `swTestEntry` before capture has no effect.
- R7: Once test mode is entered, `outMode` never returns to 0 until `rstN` is asserted, even if `swTestEntry` is cleared.
- R8: Captured code 111 sets `freqReserved` and leaves `freqCode` at its reset value 0.
- R9: In mode 2, `refDivClk` is a square wave with a period of DIV_N clocks. It starts low and toggles on every DIV_N/2-th rising edge counted while in mode 2. In any other mode it is held low from the next edge on.
- R10: Asserting `rstN` clears the test state and all captured straps, and allows a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| pwrGoodN | input | 1 | Power-good indication, active low |
| fsStrap | input | 3 | Frequency-select straps {C,B,A} |
| itpEnStrap | input | 1 | Shared pair select strap |
| testSelStrap | input | 1 | Test-select strap, already resolved to a logic level |
| testModePin | input | 1 | Live test-mode pin |
| swTestEntry | input | 1 | Software test-entry control bit |
| swTestRefN | input | 1 | Software mode choice bit (1 = divided reference) |
| strapReadback | output | 3 | Captured {C,B,A} for readback |
| freqCode | output | 3 | CPU frequency code |
| freqReserved | output | 1 | Reserved strap code was captured |
| cpuPairSel | output | 1 | Shared pair carries the CPU debug clock |
| outMode | output | 2 | 0 normal, 1 high impedance, 2 divided reference |
| refDivClk | output | 1 | Divided reference clock |

## Verification
The bench moves the straps and toggles power-good again after the first capture. A design that re-samples would change the readback or the frequency code. It clears the software entry bit and toggles the test pin after a software entry. A design with a non-sticky test state would fall back to normal mode, and one that does not hand control to software would follow the pin. It drives software entry before capture, which an ungated design would obey. It captures the reserved code, which a careless decoder would turn into a bogus frequency. It also counts divider edges across mode changes, where an off-by-one counter or a divider that does not clear shows up at once.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HIZ    = 2'd1,
    MODE_REFDIV = 2'd2
  } outMode_e;

  typedef struct packed {
    logic capture;
    logic divRun;
  } ctrlStrobe_t;

  localparam int FS_W   = 3;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_100 = 3'd0;

  function automatic logic [CODE_W-1:0] fsToCode(input logic [FS_W-1:0] fs);
    logic [CODE_W-1:0] c;
    case (fs)
      3'b000:  c = 3'd4;
      3'b001:  c = 3'd1;
      3'b010:  c = 3'd3;
      3'b011:  c = 3'd2;
      3'b100:  c = 3'd5;
      3'b101:  c = 3'd0;
      3'b110:  c = 3'd6;
      default: c = CODE_100;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGoodN,
  input  logic        testSelLat,
  input  logic        testModePin,
  input  logic        swTestEntry,
  input  logic        swTestRefN,
  output ctrlStrobe_t strobe,
  output outMode_e    mode,
  output logic        capDone,
  output logic        swOwned
);

  logic captureNow;

  assign captureNow = !capDone && !pwrGoodN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDone <= 1'b0;
      swOwned <= 1'b0;
    end else begin
      if (captureNow) capDone <= 1'b1;
      if (capDone && swTestEntry) swOwned <= 1'b1;
    end
  end

  always_comb begin
    if (swOwned)
      mode = swTestRefN ? MODE_REFDIV : MODE_HIZ;
    else if (testSelLat)
      mode = testModePin ? MODE_REFDIV : MODE_HIZ;
    else
      mode = MODE_NORMAL;
  end

  assign strobe.capture = captureNow;
  assign strobe.divRun  = (mode == MODE_REFDIV);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int DIV_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [FS_W-1:0]   fsIn,
  input  logic              itpIn,
  input  logic              testSelIn,
  output logic [FS_W-1:0]   fsLat,
  output logic              itpLat,
  output logic              testSelLat,
  output logic [CODE_W-1:0] freqCode,
  output logic              freqRsv,
  output logic              divClk
);

  localparam int HALF = DIV_N / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [FS_W-1:0] FS_RSV = {FS_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsLat      <= '0;
      itpLat     <= 1'b0;
      testSelLat <= 1'b0;
      freqCode   <= CODE_100;
      freqRsv    <= 1'b0;
    end else if (strobe.capture) begin
      fsLat      <= fsIn;
      itpLat     <= itpIn;
      testSelLat <= testSelIn;
      freqRsv    <= (fsIn == FS_RSV);
      if (fsIn != FS_RSV) freqCode <= fsToCode(fsIn);
    end
  end

  generate
    if (HALF <= 1) begin : g_div2
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              divClk <= 1'b0;
        else if (strobe.divRun) divClk <= ~divClk;
        else                    divClk <= 1'b0;
      end
    end else begin : g_divn
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cnt    <= '0;
          divClk <= 1'b0;
        end else if (strobe.divRun) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt    <= '0;
            divClk <= ~divClk;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt    <= '0;
          divClk <= 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
  import strap_pkg::*;
#(
  parameter int DIV_N = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGoodN,
  input  logic [2:0] fsStrap,
  input  logic       itpEnStrap,
  input  logic       testSelStrap,
  input  logic       testModePin,
  input  logic       swTestEntry,
  input  logic       swTestRefN,
  output logic [2:0] strapReadback,
  output logic [2:0] freqCode,
  output logic       freqReserved,
  output logic       cpuPairSel,
  output logic [1:0] outMode,
  output logic       refDivClk
);

  ctrlStrobe_t strobe;
  outMode_e    modeSel;
  logic        testSelLat;
  logic        capDone;
  logic        swOwned;

  strap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrGoodN   (pwrGoodN),
    .testSelLat (testSelLat),
    .testModePin(testModePin),
    .swTestEntry(swTestEntry),
    .swTestRefN (swTestRefN),
    .strobe     (strobe),
    .mode       (modeSel),
    .capDone    (capDone),
    .swOwned    (swOwned)
  );

  strap_datapath #(.DIV_N(DIV_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fsIn      (fsStrap),
    .itpIn     (itpEnStrap),
    .testSelIn (testSelStrap),
    .fsLat     (strapReadback),
    .itpLat    (cpuPairSel),
    .testSelLat(testSelLat),
    .freqCode  (freqCode),
    .freqRsv   (freqReserved),
    .divClk    (refDivClk)
  );

  assign outMode = modeSel;

endmodule

// File: rtl/strap_test_ctrl_chk.sv
module strap_test_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       capDone,
  input logic       swOwned,
  input logic       swTestRefN,
  input logic [2:0] strapReadback,
  input logic [2:0] freqCode,
  input logic       freqReserved,
  input logic [1:0] outMode,
  input logic       refDivClk
);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    capDone |=> $stable(strapReadback));

  // R7
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode != 2'd0) |=> (outMode != 2'd0));

  // R6
  sw_owns_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    swOwned |-> (outMode == (swTestRefN ? 2'd2 : 2'd1)));

  // R8
  rsv_code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freqReserved) |-> $stable(freqCode));

  // R9
  div_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outMode != 2'd2) |=> !refDivClk);

endmodule

bind strap_test_ctrl strap_test_ctrl_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .capDone      (capDone),
  .swOwned      (swOwned),
  .swTestRefN   (swTestRefN),
  .strapReadback(strapReadback),
  .freqCode     (freqCode),
  .freqReserved (freqReserved),
  .outMode      (outMode),
  .refDivClk    (refDivClk)
);

// File: tb/strap_test_ctrl_tb.sv
module strap_test_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int DIV_N = 6;
  localparam int HALF  = DIV_N / 2;

  logic clk = 1'b0;
  logic rstN, pwrGoodN, itpEnStrap, testSelStrap, testModePin, swTestEntry, swTestRefN;
  logic [2:0] fsStrap;
  logic [2:0] strapReadback, freqCode;
  logic freqReserved, cpuPairSel, refDivClk;
  logic [1:0] outMode;

  int checks = 0;
  int errors = 0;
  string modeTag = "R5";

  always #(CLK_P/2) clk = ~clk;

  strap_test_ctrl #(.DIV_N(DIV_N)) u_dut (
    .clk(clk), .rstN(rstN), .pwrGoodN(pwrGoodN), .fsStrap(fsStrap),
    .itpEnStrap(itpEnStrap), .testSelStrap(testSelStrap), .testModePin(testModePin),
    .swTestEntry(swTestEntry), .swTestRefN(swTestRefN),
    .strapReadback(strapReadback), .freqCode(freqCode), .freqReserved(freqReserved),
    .cpuPairSel(cpuPairSel), .outMode(outMode), .refDivClk(refDivClk)
  );

  // behavioural reference
  bit mLat, mItp, mHw, mSw, mRsv, mDiv;
  int mRb, mCode, mCnt;

  function automatic int codeOf(int fs);
    case (fs)
      0: return 4; 1: return 1; 2: return 3; 3: return 2;
      4: return 5; 5: return 0; 6: return 6; default: return -1;
    endcase
  endfunction

  function automatic int modeOf();
    if (mSw) return swTestRefN ? 2 : 1;
    if (mHw) return testModePin ? 2 : 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLat = 0; mItp = 0; mHw = 0; mSw = 0; mRsv = 0; mDiv = 0;
      mRb = 0; mCode = 0; mCnt = 0;
    end else begin
      if (modeOf() == 2) begin
        if (mCnt == HALF - 1) begin mCnt = 0; mDiv = ~mDiv; end
        else mCnt++;
      end else begin
        mCnt = 0; mDiv = 0;
      end
      if (mLat && swTestEntry) mSw = 1;
      if (!mLat && !pwrGoodN) begin
        mLat = 1; mRb = fsStrap; mItp = itpEnStrap; mHw = testSelStrap;
        mRsv = (fsStrap == 3'b111);
        if (fsStrap != 3'b111) mCode = codeOf(fsStrap);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(strapReadback == mRb[2:0], "R2", strapReadback, mRb);
    chk(freqCode == mCode[2:0], "R3", freqCode, mCode);
    chk(freqReserved == mRsv, "R8", freqReserved, mRsv);
    chk(cpuPairSel == mItp, "R4", cpuPairSel, mItp);
    chk(int'(outMode) == modeOf(), modeTag, outMode, modeOf());
    chk(refDivClk == mDiv, "R9", refDivClk, mDiv);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    rstN = 1'b0; pwrGoodN = 1'b1;
    cyc(2);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; pwrGoodN = 1'b1; fsStrap = 3'b000; itpEnStrap = 1'b0;
    testSelStrap = 1'b0; testModePin = 1'b0; swTestEntry = 1'b0; swTestRefN = 1'b0;
    cyc(2);
    // R1 reset state
    chk(strapReadback == 0 && freqCode == 0 && freqReserved == 0 && cpuPairSel == 0
        && outMode == 0 && refDivClk == 0, "R1", {strapReadback, freqCode}, 0);
    rstN = 1'b1;
    cyc(1);
    chk(outMode == 0 && freqCode == 0, "R1", outMode, 0);

    // R2: no capture while power-good is high; capture once, then hold
    fsStrap = 3'b110; itpEnStrap = 1'b1; cyc(3);
    fsStrap = 3'b000; pwrGoodN = 1'b0; cyc(1);
    chk(strapReadback == 3'b000 && freqCode == 3'd4 && cpuPairSel == 1, "R2", strapReadback, 0);
    fsStrap = 3'b011; itpEnStrap = 1'b0; testSelStrap = 1'b1; cyc(3);
    pwrGoodN = 1'b1; cyc(2); pwrGoodN = 1'b0; cyc(3);
    chk(strapReadback == 3'b000 && outMode == 0, "R2", strapReadback, 0);

    // R6: software entry before capture has no effect
    doReset(); modeTag = "R6";
    testSelStrap = 1'b0; swTestEntry = 1'b1; swTestRefN = 1'b1; cyc(4);
    chk(outMode == 0, "R6", outMode, 0);
    swTestEntry = 1'b0; pwrGoodN = 1'b0; cyc(4);
    chk(outMode == 0, "R6", outMode, 0);

    // R3 / R8 / R4: every strap code
    modeTag = "R5";
    for (int f = 0; f < 8; f++) begin
      doReset();
      fsStrap = 3'(f); itpEnStrap = f[0]; testSelStrap = 1'b0;
      pwrGoodN = 1'b0; cyc(2);
      if (f == 7) chk(freqReserved && freqCode == 0, "R8", freqCode, 0);
      else chk(int'(freqCode) == codeOf(f) && !freqReserved, "R3", freqCode, codeOf(f));
      chk(cpuPairSel == f[0], "R4", cpuPairSel, f[0]);
    end

    // R5 / R9: strap-entered test, pin chooses live
    doReset();
    testSelStrap = 1'b1; testModePin = 1'b0; pwrGoodN = 1'b0; cyc(2);
    chk(outMode == 1, "R5", outMode, 1);
    testModePin = 1'b1; cyc(20);
    testModePin = 1'b0; cyc(3);
    chk(refDivClk == 0, "R9", refDivClk, 0);
    testModePin = 1'b1; cyc(1); testModePin = 1'b0; cyc(1); testModePin = 1'b1; cyc(13);

    // R6 / R7: software entry on top of normal, pin ignored, bit cleared
    doReset(); modeTag = "R6";
    testSelStrap = 1'b0; testModePin = 1'b0; pwrGoodN = 1'b0; cyc(2);
    swTestRefN = 1'b1; swTestEntry = 1'b1; cyc(1); swTestEntry = 1'b0; cyc(1);
    chk(outMode == 2, "R6", outMode, 2);
    modeTag = "R7";
    testModePin = 1'b0; cyc(5); testModePin = 1'b1; cyc(3);
    swTestRefN = 1'b0; cyc(3);
    chk(outMode == 1, "R7", outMode, 1);
    swTestRefN = 1'b1; cyc(10);

    // R6: software takes over from a strap entry
    doReset(); modeTag = "R6";
    testSelStrap = 1'b1; testModePin = 1'b1; pwrGoodN = 1'b0; cyc(4);
    swTestRefN = 1'b0; swTestEntry = 1'b1; cyc(1); swTestEntry = 1'b0; cyc(1);
    chk(outMode == 1, "R6", outMode, 1);

    // R10: reset clears test and straps, then recapture
    rstN = 1'b0; cyc(1);
    chk(outMode == 0 && strapReadback == 0, "R10", outMode, 0);
    rstN = 1'b1; testSelStrap = 1'b0; fsStrap = 3'b101; pwrGoodN = 1'b1; cyc(1);
    chk(outMode == 0, "R10", outMode, 0);
    pwrGoodN = 1'b0; cyc(2);
    chk(strapReadback == 3'b101 && freqCode == 0, "R10", strapReadback, 5);

    cyc(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule